// File: doc/BRIEF.md
# Legacy Expansion Bus I/O Slave Controller

This block lets a peripheral answer I/O cycles on a legacy 8/16-bit expansion bus. It captures the system address when the address strobe falls and matches it against a fixed, aligned window of I/O ports. It then turns a read or write command strobe into a single request on a simple register port towards the peripheral core. Bus control lines are modelled as pull-low outputs: a `1` on a `*_pull` port means the block pulls that line low, and a `0` means it lets the line go. The data bus has a separate output enable.

Each register in the window takes one of two speed classes, set by a per-index parameter mask. A fast register shortens the bus cycle by pulling the no-wait-state line. A slow register stretches the cycle by pulling the channel-ready line low until the core answers, and that pull is cut off after a set number of clocks. When the cut-off fires, the block latches a timeout flag that only reset clears. While a DMA controller owns the bus, command strobes are ignored.

All bus inputs are taken to be already synchronous to `clk`. The asynchronous reset is released through a two-stage synchronizer.

Top module: `isa_io_slave`

## Requirements
- R1: The address is captured at the first clock edge that samples `bus_addr_strobe` low after it was high. It counts as a hit only while the strobe stays low and the captured address lies in `BASE_ADDR .. BASE_ADDR+NREG-1`. With defaults this is 0x300..0x307. A command strobe to any other address raises no request and drives no bus line.
- R2: While `bus_dma_own` is 1, command strobes start no cycle. There is then no request, no data enable, no wait pull and no fast pull, and `bus_wide_pull` stays 0.
- R3: A read of a hit address issues one request with `reg_we`=0 and `reg_idx` equal to the low address bits. `bus_data_o` takes `reg_rdata` at the edge that sees `reg_ready`. `bus_data_oe` is 1 only while a read cycle is in progress and `bus_rd_n` is low, and it drops at the first clock edge that samples `bus_rd_n` high.
- R4: A write of a hit address issues one request with `reg_we`=1, and `reg_wdata` holds `bus_data_i` as sampled at the edge that starts the cycle. If both command strobes are low at once, the cycle is taken as a write.
- R5: For an index whose bit in `FAST_MASK` is 1 (defaults: indices 0..3), `bus_fast_pull` is 1 while the cycle is active and its command strobe is low. `bus_wait_pull` stays 0 for the whole cycle.
- R6: For an index whose `FAST_MASK` bit is 0, `bus_wait_pull` is 1 from the edge that starts the cycle up to and including the cycle in which `reg_ready` is sampled. If ready is given N clocks after the request appears, the line is held for N+1 clocks.
- R7: `bus_wait_pull` and `bus_fast_pull` are never 1 in the same cycle.
- R8: If the core does not answer within `MAX_WAIT` clocks (default 16), the request is withdrawn and `bus_wait_pull` is released after exactly `MAX_WAIT` clocks. `wait_timeout` then becomes 1 and stays 1 until reset.
- R9: With `WIDE16`=1, `bus_wide_pull` is 1 whenever a hit address is captured and `bus_dma_own` is 0.
- R10: During and right after reset, `reg_req`, `bus_data_oe`, `bus_wait_pull`, `bus_fast_pull`, `bus_wide_pull` and `wait_timeout` are all 0.
- R11: A command strobe yields at most one request. After the access completes, no new request starts until both command strobes have been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | System I/O address lines |
| bus_addr_strobe | input | 1 | Address latch strobe; address is valid after its fall |
| bus_dma_own | input | 1 | 1 while a DMA controller owns the bus |
| bus_rd_n | input | 1 | I/O read command, active low |
| bus_wr_n | input | 1 | I/O write command, active low |
| bus_data_i | input | DATA_W | Data bus, inbound |
| bus_data_o | output | DATA_W | Data bus, outbound |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_wait_pull | output | 1 | Pull channel-ready low (extend cycle) |
| bus_fast_pull | output | 1 | Pull no-wait-state low (shorten cycle) |
| bus_wide_pull | output | 1 | Pull the 16-bit I/O size line low |
| reg_req | output | 1 | Register access request, held until ready or timeout |
| reg_we | output | 1 | 1 for write, 0 for read |
| reg_idx | output | $clog2(NREG) | Register index inside the window |
| reg_wdata | output | DATA_W | Write data |
| reg_rdata | input | DATA_W | Read data from the core |
| reg_ready | input | 1 | Core completes the access |
| wait_timeout | output | 1 | Sticky: a wait cycle was cut off |

## Verification
The bench targets the edges of the window (0x307 is inside, 0x308 is outside) and DMA ownership during an in-window strobe. A decoder that is off by one, or that ignores DMA ownership, would push an unexpected request into the scoreboard. It measures how many clocks channel ready is held low, for both a late answer and no answer at all. A counter that is off by one, or a release that is missing, shows up as a wrong run length or a missing sticky flag. Strobes are held well past completion, so a controller that re-triggers would issue a second request. The bench also watches the data enable on the clock after the read strobe rises, so an enable left on would collide with the next bus owner.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

  // Bus cycle phases seen from the slave.
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,  // waiting for a qualified command strobe
    CYC_WAIT = 2'd1,  // request outstanding towards the core
    CYC_HOLD = 2'd2   // access done, waiting for strobes to release
  } cyc_state_e;

endpackage

// File: rtl/isa_io_decode.sv
module isa_io_decode #(
  parameter int              ADDR_W    = 10,
  parameter int              NREG      = 8,
  parameter int              BASE_ADDR = 'h300,
  parameter logic [NREG-1:0] FAST_MASK = '0,
  parameter bit              WIDE16    = 1'b1,
  localparam int             IDX_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_addr_strobe,
  input  logic              bus_dma_own,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              fast,
  output logic              wide_pull
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

  logic              stb_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              valid_q, valid_d;
  logic              cap_en;

  // Capture on the first sample after the strobe fell.
  assign cap_en = stb_q && !bus_addr_strobe;

  always_comb begin
    addr_d  = addr_q;
    valid_d = valid_q;
    if (bus_addr_strobe) begin
      valid_d = 1'b0;
    end else if (cap_en) begin
      addr_d  = bus_addr;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      stb_q   <= bus_addr_strobe;
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end

  assign hit  = valid_q && (addr_q[ADDR_W-1:IDX_W] == BASE_V[ADDR_W-1:IDX_W]);
  assign idx  = addr_q[IDX_W-1:0];
  assign fast = FAST_MASK[idx];

  generate
    if (WIDE16) begin : g_wide
      assign wide_pull = hit && !bus_dma_own;
    end else begin : g_narrow
      assign wide_pull = 1'b0;
    end
  endgenerate

  // R1: a hit only appears after a clock that saw the strobe low.
  a_r1_hit_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> ($past(bus_addr_strobe) == 1'b0));

  // R1: a rising strobe withdraws the decode.
  a_r1_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_strobe |=> !hit);

endmodule

// File: rtl/isa_io_seq.sv
module isa_io_seq
  import isa_io_pkg::*;
#(
  parameter int  MAX_WAIT = 16,
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       strobe_act,
  input  logic       fast,
  input  logic       user_ready,
  output cyc_state_e state,
  output logic       req,
  output logic       wait_pull,
  output logic       fast_pull,
  output logic       timeout_flag
);

  cyc_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              fast_q, fast_d;
  logic              tout_q, tout_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fast_d  = fast_q;
    tout_d  = tout_q;
    unique case (state_q)
      CYC_IDLE: begin
        if (start) begin
          state_d = CYC_WAIT;
          cnt_d   = '0;
          fast_d  = fast;
        end
      end
      CYC_WAIT: begin
        if (user_ready) begin
          state_d = CYC_HOLD;
        end else if (cnt_q == WAIT_W'(MAX_WAIT - 1)) begin
          state_d = CYC_HOLD;
          tout_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CYC_HOLD: begin
        if (!strobe_act) state_d = CYC_IDLE;
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      cnt_q   <= '0;
      fast_q  <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fast_q  <= fast_d;
      tout_q  <= tout_d;
    end
  end

  assign state        = state_q;
  assign req          = (state_q == CYC_WAIT);
  assign wait_pull    = (state_q == CYC_WAIT) && !fast_q;
  assign fast_pull    = (state_q != CYC_IDLE) && fast_q && strobe_act;
  assign timeout_flag = tout_q;

  // Run-length counter used only by the R8 bound check.
  logic [WAIT_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (wait_pull) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  // R7: never shorten and stretch at once.
  a_r7_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_pull && fast_pull));

  // R6: a ready answer releases the channel on the next clock.
  a_r6_release_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_pull && user_ready) |=> !wait_pull);

  // R8: the wait pull never exceeds MAX_WAIT consecutive clocks.
  a_r8_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wait_pull |-> (run_q < WAIT_W'(MAX_WAIT)));

  // R8: the timeout flag is sticky.
  a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  // R11: a held strobe never restarts a request.
  a_r11_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CYC_HOLD && strobe_act) |=> !req);

endmodule

// File: rtl/isa_io_datapath.sv
module isa_io_datapath #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_cmd,
  input  logic              rd_n,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] user_rdata,
  output logic [IDX_W-1:0]  idx_q,
  output logic              we_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              oe_q
);

  logic              cap_en;
  logic              dout_en;
  logic              oe_d;
  logic [IDX_W-1:0]  idx_d;
  logic              we_d;
  logic [DATA_W-1:0] wdata_d;
  logic [DATA_W-1:0] dout_d;

  assign cap_en  = start;
  assign dout_en = rd_done && !we_q;

  always_comb begin
    idx_d   = cap_en  ? idx_in     : idx_q;
    we_d    = cap_en  ? wr_cmd     : we_q;
    wdata_d = cap_en  ? data_in    : wdata_q;
    dout_d  = dout_en ? user_rdata : dout_q;
    oe_d    = busy && !we_q && !rd_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      dout_q  <= '0;
      oe_q    <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
    end
  end

  // R3: the enable drops on the clock after the read strobe rises.
  a_r3_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> !oe_q);

  // R3: the enable is only on after an active read strobe.
  a_r3_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> ($past(rd_n) == 1'b0));

endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
  import isa_io_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter int              DATA_W    = 16,
  parameter int              NREG      = 8,
  parameter int              BASE_ADDR = 'h300,
  parameter logic [NREG-1:0] FAST_MASK = 8'h0F,
  parameter int              MAX_WAIT  = 16,
  parameter bit              WIDE16    = 1'b1,
  localparam int             IDX_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_addr_strobe,
  input  logic              bus_dma_own,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  output logic              bus_wait_pull,
  output logic              bus_fast_pull,
  output logic              bus_wide_pull,
  output logic              reg_req,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ready,
  output logic              wait_timeout
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             hit;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_fast;
  logic             strobe_act;
  logic             start;
  cyc_state_e       state;
  logic             busy;

  assign strobe_act = !bus_rd_n || !bus_wr_n;
  assign busy       = (state != CYC_IDLE);
  assign start      = (state == CYC_IDLE) && strobe_act && hit && !bus_dma_own;

  isa_io_decode #(
    .ADDR_W    (ADDR_W),
    .NREG      (NREG),
    .BASE_ADDR (BASE_ADDR),
    .FAST_MASK (FAST_MASK),
    .WIDE16    (WIDE16)
  ) i_decode (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .bus_addr        (bus_addr),
    .bus_addr_strobe (bus_addr_strobe),
    .bus_dma_own     (bus_dma_own),
    .hit             (hit),
    .idx             (dec_idx),
    .fast            (dec_fast),
    .wide_pull       (bus_wide_pull)
  );

  isa_io_seq #(
    .MAX_WAIT (MAX_WAIT)
  ) i_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start        (start),
    .strobe_act   (strobe_act),
    .fast         (dec_fast),
    .user_ready   (reg_ready),
    .state        (state),
    .req          (reg_req),
    .wait_pull    (bus_wait_pull),
    .fast_pull    (bus_fast_pull),
    .timeout_flag (wait_timeout)
  );

  isa_io_datapath #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .wr_cmd     (!bus_wr_n),
    .rd_n       (bus_rd_n),
    .busy       (busy),
    .rd_done    (reg_req && reg_ready),
    .idx_in     (dec_idx),
    .data_in    (bus_data_i),
    .user_rdata (reg_rdata),
    .idx_q      (reg_idx),
    .we_q       (reg_we),
    .wdata_q    (reg_wdata),
    .dout_q     (bus_data_o),
    .oe_q       (bus_data_oe)
  );

  // R2: DMA ownership never lets a request start.
  a_r2_dma_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!reg_req && bus_dma_own) |=> !reg_req);

  // R1: a request only follows an address captured in the window.
  a_r1_req_needs_hit: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(reg_req) |-> $past(hit));

endmodule

// File: tb/test_isa_io_slave.sv
`timescale 1ns/1ps
module test_isa_io_slave;

  logic        clk;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_addr_strobe;
  logic        bus_dma_own;
  logic        bus_rd_n;
  logic        bus_wr_n;
  logic [15:0] bus_data_i;
  logic [15:0] bus_data_o;
  logic        bus_data_oe;
  logic        bus_wait_pull;
  logic        bus_fast_pull;
  logic        bus_wide_pull;
  logic        reg_req;
  logic        reg_we;
  logic [2:0]  reg_idx;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        reg_ready;
  logic        wait_timeout;

  isa_io_slave i_isa_io_slave (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_addr_strobe (bus_addr_strobe),
    .bus_dma_own     (bus_dma_own),
    .bus_rd_n        (bus_rd_n),
    .bus_wr_n        (bus_wr_n),
    .bus_data_i      (bus_data_i),
    .bus_data_o      (bus_data_o),
    .bus_data_oe     (bus_data_oe),
    .bus_wait_pull   (bus_wait_pull),
    .bus_fast_pull   (bus_fast_pull),
    .bus_wide_pull   (bus_wide_pull),
    .reg_req         (reg_req),
    .reg_we          (reg_we),
    .reg_idx         (reg_idx),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .reg_ready       (reg_ready),
    .wait_timeout    (wait_timeout)
  );

  localparam int MAX_WAIT = 16;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int n_req  = 0;

  typedef struct packed {
    logic        we;
    logic [2:0]  idx;
    logic [15:0] data;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
    end
  endtask

  // Core model: read data derived from the index.
  assign reg_rdata = 16'hA500 ^ {13'h0, reg_idx};

  int rdy_delay = 0;
  int rcnt      = 0;
  always @(negedge clk) begin
    if (reg_req && !reg_ready) begin
      if (rcnt >= rdy_delay) reg_ready = 1'b1;
      else                   rcnt++;
    end else begin
      reg_ready = 1'b0;
      rcnt      = 0;
    end
  end

  // Monitor: every new request is compared with the scoreboard head.
  logic prev_req = 1'b0;
  always @(negedge clk) begin
    if (reg_req && !prev_req) begin
      n_req++;
      if (sb.size() == 0) begin
        chk(1'b0, "R11", "request with none expected (R1 R2)", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(reg_we == e.we && reg_idx == e.idx && (!e.we || reg_wdata == e.data),
            e.we ? "R4" : "R3", "request fields",
            int'({reg_we, reg_idx, reg_wdata}), int'(e));
      end
    end
    prev_req = reg_req;
  end

  task automatic io_cycle(input logic [9:0] a, input bit wr, input logic [15:0] d,
                          input bit dma, input bit hit_exp, input int delay,
                          input bit fast_exp, input bit tout_exp, input string tag);
    bit live;
    bit saw_fast, saw_wait, saw_both, saw_oe;
    int req0, run, maxrun;
    live = hit_exp && !dma;
    saw_fast = 0; saw_wait = 0; saw_both = 0; saw_oe = 0;
    run = 0; maxrun = 0;
    rdy_delay = delay;
    @(negedge clk);
    bus_addr = a; bus_addr_strobe = 1'b1; bus_dma_own = dma;
    @(negedge clk);
    bus_addr_strobe = 1'b0;
    @(negedge clk);
    chk(bus_wide_pull == live, "R9", {tag, " size16 pull"}, int'(bus_wide_pull), int'(live));
    req0 = n_req;
    if (live) sb.push_back(exp_t'{wr, a[2:0], d});
    bus_data_i = d;
    if (wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      saw_fast |= bus_fast_pull;
      saw_wait |= bus_wait_pull;
      saw_both |= bus_fast_pull && bus_wait_pull;
      saw_oe   |= bus_data_oe;
      if (bus_wait_pull) run++; else run = 0;
      if (run > maxrun) maxrun = run;
      if (k >= 3 && !bus_wait_pull) break;
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      saw_fast |= bus_fast_pull;
      saw_wait |= bus_wait_pull;
      saw_both |= bus_fast_pull && bus_wait_pull;
      saw_oe   |= bus_data_oe;
    end
    if (live && !wr) begin
      chk(bus_data_oe == 1'b1, "R3", {tag, " oe during read"}, int'(bus_data_oe), 1);
      if (!tout_exp)
        chk(bus_data_o == (16'hA500 ^ {13'h0, a[2:0]}), "R3", {tag, " read data"},
            int'(bus_data_o), int'(16'hA500 ^ {13'h0, a[2:0]}));
    end
    bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    @(negedge clk);
    chk(bus_data_oe == 1'b0, "R3", {tag, " oe released"}, int'(bus_data_oe), 0);
    chk((n_req - req0) == int'(live), "R11", {tag, " requests per strobe"},
        n_req - req0, int'(live));
    if (!live) begin
      chk(!saw_fast && !saw_wait && !saw_oe, dma ? "R2" : "R1", {tag, " bus untouched"},
          int'({saw_fast, saw_wait, saw_oe}), 0);
    end else if (fast_exp) begin
      chk(saw_fast && maxrun == 0, "R5", {tag, " fast path"}, maxrun, 0);
    end else if (tout_exp) begin
      chk(maxrun == MAX_WAIT, "R8", {tag, " wait cut off"}, maxrun, MAX_WAIT);
    end else begin
      chk(maxrun == delay + 1 && !saw_fast, "R6", {tag, " wait length"}, maxrun, delay + 1);
    end
    chk(!saw_both, "R7", {tag, " exclusive pulls"}, int'(saw_both), 0);
    bus_dma_own = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_addr_strobe = 1'b0; bus_dma_own = 1'b0;
    bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_data_i = '0;
    reg_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk({reg_req, bus_data_oe, bus_wait_pull, bus_fast_pull, bus_wide_pull, wait_timeout} == 6'b0,
        "R10", "outputs in reset",
        int'({reg_req, bus_data_oe, bus_wait_pull, bus_fast_pull, bus_wide_pull, wait_timeout}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({reg_req, bus_data_oe, bus_wait_pull, bus_fast_pull, wait_timeout} == 5'b0,
        "R10", "outputs after reset",
        int'({reg_req, bus_data_oe, bus_wait_pull, bus_fast_pull, wait_timeout}), 0);

    io_cycle(10'h305, 1'b0, 16'h0000, 1'b0, 1'b1, 3, 1'b0, 1'b0, "slow read");
    io_cycle(10'h306, 1'b1, 16'h1234, 1'b0, 1'b1, 0, 1'b0, 1'b0, "slow write");
    io_cycle(10'h301, 1'b0, 16'h0000, 1'b0, 1'b1, 0, 1'b1, 1'b0, "fast read");
    io_cycle(10'h303, 1'b1, 16'hBEEF, 1'b0, 1'b1, 0, 1'b1, 1'b0, "fast write");
    io_cycle(10'h307, 1'b0, 16'h0000, 1'b0, 1'b1, 5, 1'b0, 1'b0, "top of window");
    io_cycle(10'h302, 1'b1, 16'h5A5A, 1'b1, 1'b1, 0, 1'b1, 1'b0, "dma owns bus");
    io_cycle(10'h308, 1'b0, 16'h0000, 1'b0, 1'b0, 0, 1'b0, 1'b0, "just above window");
    io_cycle(10'h200, 1'b1, 16'h7777, 1'b0, 1'b0, 0, 1'b0, 1'b0, "far outside");
    chk(wait_timeout == 1'b0, "R8", "no timeout yet", int'(wait_timeout), 0);
    io_cycle(10'h304, 1'b0, 16'h0000, 1'b0, 1'b1, 1000, 1'b0, 1'b1, "no answer");
    chk(wait_timeout == 1'b1, "R8", "timeout flag set", int'(wait_timeout), 1);
    io_cycle(10'h300, 1'b0, 16'h0000, 1'b0, 1'b1, 0, 1'b1, 1'b0, "after timeout");
    chk(wait_timeout == 1'b1, "R8", "timeout flag sticky", int'(wait_timeout), 1);

    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule